// File: doc/BRIEF.md
# Configuration Port Unlock Controller

This block is a keyed configuration interface that sits on a byte-wide host I/O bus. The bus has two ports: an index port (address 0) and a data port (address 1). While the block is locked, it watches writes to the index port for a four-byte unlock key. After the key is seen, the block enters configuration mode. In that mode the index port selects a configuration register, and the data port reads or writes that register.

The registers are:

- a chip identifier, split over two read-only registers;
- a logical device select register;
- a global flash-control register;
- a base-address pair for the serial flash engine, visible only while the flash logical device is selected.

Configuration mode ends when the exit value is written to the exit register. The last byte of the key depends on a strap input, which tells the block which of two configuration port addresses it is decoded at. The flash-control bits and the base address are driven out as ports for the flash engine.

Top module: `cfg_unlock_ctrl`

## Requirements
- R1: Four consecutive index-port writes of 0x87, 0x01, 0x55 and the final key byte make cfg_mode_o go high in the cycle after the fourth write.
- R2: The final key byte is 0x55 when strap_i is 0 (port at 0x2E) and 0xAA when strap_i is 1 (port at 0x4E). Any other final byte does not unlock.
- R3: A wrong byte during key detection restarts detection. If the wrong byte is 0x87, it counts as the first key byte.
- R4: While locked, reads of either port return 0xFF, and data-port writes change nothing.
- R5: In configuration mode, an index-port write stores the register index, and an index-port read returns it.
- R6: A data-port write of 0x02 while the index is 0x02 leaves configuration mode in the next cycle. Any other value written to register 0x02 has no effect.
- R7: Register 0x20 reads CHIP_ID[15:8] and register 0x21 reads CHIP_ID[7:0]. Writes to them are ignored.
- R8: Register 0x07 holds the logical device number as a full read/write byte, and it resets to 0.
- R9: In register 0x24, bits 4:0 are writable (bit 0 suspend, bits 1 to 3 segment enables, bit 4 host write enable). Bit 5 reads pin_sel_i and bits 7:6 read 0. gctl_o always equals this read value. The writable bits reset to 0.
- R10: With logical device 7 selected, register 0x64 holds base-address bits 11:8 (its bits 7:4 read 0), and register 0x65 holds bits 7:3 (its bits 2:0 read 0). flash_base_o shows the address, which resets to 0x0820.
- R11: A write to 0x64 or 0x65 that would make the base address zero is ignored.
- R12: With any other logical device selected, registers 0x64 and 0x65 read 0x00 and ignore writes. Unimplemented registers read 0x00.
- R13: rdata_o loads the selected value on the clock edge where rd_i is high, and it holds at all other times. It resets to 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| strap_i | input | 1 | Port strap: 0 selects port 0x2E, 1 selects port 0x4E |
| pin_sel_i | input | 1 | Flash pin select, reflected in control bit 5 |
| wr_i | input | 1 | Bus write strobe |
| rd_i | input | 1 | Bus read strobe |
| addr_i | input | 1 | Port select: 0 index, 1 data |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| cfg_mode_o | output | 1 | Configuration mode active |
| gctl_o | output | 8 | Global flash-control value |
| flash_base_o | output | 16 | Flash engine base address |

## Verification
The assertions check the following on every cycle:

- the base address stays aligned, nonzero and below 0x1000;
- a data-port write while locked leaves the control bits and the base address untouched;
- entering configuration mode always follows an index write of the correct strap-dependent final byte;
- the exit write always locks the block;
- reads while locked return 0xFF.

Only the bench's scenarios can show the rest: restarting on a wrong key byte (including the 0x87 re-sync), the identifier values, gating of the base registers by the logical device number, and rejection of zero-producing writes.

// File: rtl/cfg_unlock_pkg.sv
package cfg_unlock_pkg;
  typedef enum logic [1:0] {KEY_IDLE, KEY_B1, KEY_B2, KEY_B3} key_st_e;

  localparam logic [7:0] KEY_FIRST   = 8'h87;
  localparam logic [7:0] KEY_SECOND  = 8'h01;
  localparam logic [7:0] KEY_THIRD   = 8'h55;
  localparam logic [7:0] KEY_LAST_LO = 8'h55;  // strap 0: port 0x2E
  localparam logic [7:0] KEY_LAST_HI = 8'hAA;  // strap 1: port 0x4E

  localparam logic [7:0] REG_EXIT    = 8'h02;
  localparam logic [7:0] EXIT_VAL    = 8'h02;
  localparam logic [7:0] REG_LDN     = 8'h07;
  localparam logic [7:0] REG_ID_HI   = 8'h20;
  localparam logic [7:0] REG_ID_LO   = 8'h21;
  localparam logic [7:0] REG_GCTL    = 8'h24;
  localparam logic [7:0] REG_BASE_HI = 8'h64;
  localparam logic [7:0] REG_BASE_LO = 8'h65;
  localparam logic [7:0] LDN_FLASH   = 8'h07;

  localparam int GCTL_W = 5;
endpackage

// File: rtl/cfg_key_detect.sv
module cfg_key_detect
  import cfg_unlock_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       strap_i,
  input  logic       key_wr_i,
  input  logic [7:0] wdata_i,
  input  logic       exit_i,
  output logic       unlocked_o
);
  key_st_e    st_q;
  logic [7:0] exp_byte;

  always_comb begin
    unique case (st_q)
      KEY_IDLE: exp_byte = KEY_FIRST;
      KEY_B1:   exp_byte = KEY_SECOND;
      KEY_B2:   exp_byte = KEY_THIRD;
      default:  exp_byte = strap_i ? KEY_LAST_HI : KEY_LAST_LO;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= KEY_IDLE;
      unlocked_o <= 1'b0;
    end else if (exit_i) begin
      unlocked_o <= 1'b0;
      st_q       <= KEY_IDLE;
    end else if (key_wr_i) begin
      if (wdata_i == exp_byte) begin
        if (st_q == KEY_B3) begin
          unlocked_o <= 1'b1;
          st_q       <= KEY_IDLE;
        end else begin
          st_q <= key_st_e'(st_q + 2'd1);
        end
      end else begin
        // a stray first byte re-synchronises instead of restarting cold
        st_q <= (wdata_i == KEY_FIRST) ? KEY_B1 : KEY_IDLE;
      end
    end
  end
endmodule

// File: rtl/cfg_base_reg.sv
module cfg_base_reg #(
  parameter int          BASE_W   = 12,
  parameter int          ALIGN_W  = 3,
  parameter logic [15:0] BASE_RST = 16'h0820,
  localparam int         HI_W     = BASE_W - 8,
  localparam int         LO_W     = 8 - ALIGN_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            hi_we_i,
  input  logic [HI_W-1:0] hi_data_i,
  input  logic            lo_we_i,
  input  logic [LO_W-1:0] lo_data_i,
  output logic [15:0]     base_o
);
  logic [BASE_W-1:ALIGN_W] base_q, base_nxt;
  logic                    upd;

  always_comb begin
    base_nxt = base_q;
    if (hi_we_i) base_nxt[BASE_W-1:8] = hi_data_i;
    if (lo_we_i) base_nxt[7:ALIGN_W]  = lo_data_i;
    upd = (hi_we_i | lo_we_i) & (base_nxt != '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  base_q <= BASE_RST[BASE_W-1:ALIGN_W];
    else if (upd) base_q <= base_nxt;
  end

  assign base_o = {{(16-BASE_W){1'b0}}, base_q, {ALIGN_W{1'b0}}};
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import cfg_unlock_pkg::*;
#(
  parameter logic [15:0] CHIP_ID  = 16'h8716,
  parameter logic [15:0] BASE_RST = 16'h0820,
  parameter int          BASE_W   = 12,
  parameter int          ALIGN_W  = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        unlocked_i,
  input  logic        wr_i,
  input  logic        addr_i,
  input  logic [7:0]  wdata_i,
  input  logic        pin_sel_i,
  output logic        exit_o,
  output logic [7:0]  idx_o,
  output logic [7:0]  rd_val_o,
  output logic [7:0]  gctl_o,
  output logic [15:0] base_o
);
  localparam int HI_W = BASE_W - 8;

  logic [7:0]        idx_q, ldn_q;
  logic [GCTL_W-1:0] gctl_q;
  logic              data_we, idx_we, flash_sel;

  assign data_we   = unlocked_i & wr_i & addr_i;
  assign idx_we    = unlocked_i & wr_i & ~addr_i;
  assign flash_sel = (ldn_q == LDN_FLASH);
  assign exit_o    = data_we & (idx_q == REG_EXIT) & (wdata_i == EXIT_VAL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      ldn_q  <= '0;
      gctl_q <= '0;
    end else begin
      if (idx_we) idx_q <= wdata_i;
      if (data_we && idx_q == REG_LDN)  ldn_q  <= wdata_i;
      if (data_we && idx_q == REG_GCTL) gctl_q <= wdata_i[GCTL_W-1:0];
    end
  end

  cfg_base_reg #(
    .BASE_W  (BASE_W),
    .ALIGN_W (ALIGN_W),
    .BASE_RST(BASE_RST)
  ) u_base (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hi_we_i  (data_we & flash_sel & (idx_q == REG_BASE_HI)),
    .hi_data_i(wdata_i[HI_W-1:0]),
    .lo_we_i  (data_we & flash_sel & (idx_q == REG_BASE_LO)),
    .lo_data_i(wdata_i[7:ALIGN_W]),
    .base_o   (base_o)
  );

  assign gctl_o = {{(7-GCTL_W){1'b0}}, pin_sel_i, gctl_q};
  assign idx_o  = idx_q;

  always_comb begin
    if (!unlocked_i)  rd_val_o = 8'hFF;
    else if (!addr_i) rd_val_o = idx_q;
    else begin
      unique case (idx_q)
        REG_LDN:     rd_val_o = ldn_q;
        REG_ID_HI:   rd_val_o = CHIP_ID[15:8];
        REG_ID_LO:   rd_val_o = CHIP_ID[7:0];
        REG_GCTL:    rd_val_o = gctl_o;
        REG_BASE_HI: rd_val_o = flash_sel ? base_o[15:8] : 8'h00;
        REG_BASE_LO: rd_val_o = flash_sel ? base_o[7:0]  : 8'h00;
        default:     rd_val_o = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/cfg_unlock_ctrl.sv
module cfg_unlock_ctrl #(
  parameter logic [15:0] CHIP_ID  = 16'h8716,
  parameter logic [15:0] BASE_RST = 16'h0820,
  parameter int          BASE_W   = 12,
  parameter int          ALIGN_W  = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        strap_i,
  input  logic        pin_sel_i,
  input  logic        wr_i,
  input  logic        rd_i,
  input  logic        addr_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  output logic        cfg_mode_o,
  output logic [7:0]  gctl_o,
  output logic [15:0] flash_base_o
);
  logic       exit_w;
  logic [7:0] idx_q, rd_val;

  cfg_key_detect u_key (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .strap_i   (strap_i),
    .key_wr_i  (wr_i & ~addr_i & ~cfg_mode_o),
    .wdata_i   (wdata_i),
    .exit_i    (exit_w),
    .unlocked_o(cfg_mode_o)
  );

  cfg_regfile #(
    .CHIP_ID (CHIP_ID),
    .BASE_RST(BASE_RST),
    .BASE_W  (BASE_W),
    .ALIGN_W (ALIGN_W)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .unlocked_i(cfg_mode_o),
    .wr_i      (wr_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .pin_sel_i (pin_sel_i),
    .exit_o    (exit_w),
    .idx_o     (idx_q),
    .rd_val_o  (rd_val),
    .gctl_o    (gctl_o),
    .base_o    (flash_base_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= 8'hFF;
    else if (rd_i) rdata_o <= rd_val;
  end
endmodule

// File: rtl/cfg_unlock_chk.sv
module cfg_unlock_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        strap_i,
  input logic        wr_i,
  input logic        rd_i,
  input logic        addr_i,
  input logic [7:0]  wdata_i,
  input logic [7:0]  rdata_o,
  input logic        cfg_mode_o,
  input logic [4:0]  gctl_lo,
  input logic [15:0] flash_base_o,
  input logic [7:0]  idx_q
);
  assert_unlock_key_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_mode_o) |-> $past(wr_i && !addr_i &&
      (wdata_i == (strap_i ? 8'hAA : 8'h55))));

  assert_locked_wr_ignored_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_mode_o && wr_i && addr_i) |=> ($stable(gctl_lo) && $stable(flash_base_o)));

  assert_locked_rd_ff_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_mode_o && rd_i) |=> (rdata_o == 8'hFF));

  assert_exit_locks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_mode_o && wr_i && addr_i && idx_q == 8'h02 && wdata_i == 8'h02) |=> !cfg_mode_o);

  assert_base_aligned_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flash_base_o[2:0] == 3'b0) && (flash_base_o[15:12] == 4'b0));

  assert_base_nonzero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flash_base_o != 16'h0);

  assert_rdata_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
endmodule

bind cfg_unlock_ctrl cfg_unlock_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .strap_i     (strap_i),
  .wr_i        (wr_i),
  .rd_i        (rd_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .rdata_o     (rdata_o),
  .cfg_mode_o  (cfg_mode_o),
  .gctl_lo     (gctl_o[4:0]),
  .flash_base_o(flash_base_o),
  .idx_q       (idx_q)
);

// File: tb/sim_cfg_unlock_ctrl.sv
module sim_cfg_unlock_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap = 1'b0, pin_sel = 1'b0;
  logic        wr = 1'b0, rd = 1'b0, addr = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata, gctl;
  logic        cfg_mode;
  logic [15:0] base;

  always #2 clk = ~clk;

  cfg_unlock_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .strap_i(strap), .pin_sel_i(pin_sel),
    .wr_i(wr), .rd_i(rd), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .cfg_mode_o(cfg_mode), .gctl_o(gctl), .flash_base_o(base)
  );

  localparam logic [15:0] ID = 16'h8716;

  int total = 0, bad = 0;
  bit m_unl = 0;
  int m_st = 0;
  logic [7:0]  m_idx = '0, m_ldn = '0;
  logic [4:0]  m_gctl = '0;
  logic [15:0] m_base = 16'h0820;

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  function automatic void model_wr(bit a, logic [7:0] d);
    logic [7:0]  e;
    logic [15:0] nb;
    if (!m_unl) begin
      if (a) return;
      case (m_st)
        0: e = 8'h87;
        1: e = 8'h01;
        2: e = 8'h55;
        default: e = strap ? 8'hAA : 8'h55;
      endcase
      if (d == e) begin
        if (m_st == 3) begin m_unl = 1; m_st = 0; end
        else m_st++;
      end else m_st = (d == 8'h87) ? 1 : 0;
    end else if (!a) m_idx = d;
    else begin
      nb = m_base;
      case (m_idx)
        8'h02: if (d == 8'h02) begin m_unl = 0; m_st = 0; end
        8'h07: m_ldn = d;
        8'h24: m_gctl = d[4:0];
        8'h64: if (m_ldn == 8'h07) nb[11:8] = d[3:0];
        8'h65: if (m_ldn == 8'h07) nb[7:3] = d[7:3];
        default: ;
      endcase
      if (nb != 0) m_base = nb;
    end
  endfunction

  function automatic logic [7:0] model_rd(bit a);
    if (!m_unl) return 8'hFF;
    if (!a) return m_idx;
    case (m_idx)
      8'h07: return m_ldn;
      8'h20: return ID[15:8];
      8'h21: return ID[7:0];
      8'h24: return {2'b00, pin_sel, m_gctl};
      8'h64: return (m_ldn == 8'h07) ? m_base[15:8] : 8'h00;
      8'h65: return (m_ldn == 8'h07) ? m_base[7:0] : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string req_of(bit a);
    if (!m_unl) return "R4";
    if (!a) return "R5";
    case (m_idx)
      8'h02: return "R6";
      8'h07: return "R8";
      8'h20, 8'h21: return "R7";
      8'h24: return "R9";
      8'h64, 8'h65: return (m_ldn == 8'h07) ? "R10" : "R12";
      default: return "R12";
    endcase
  endfunction

  task automatic bwr(bit a, logic [7:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0;
    model_wr(a, d);
  endtask

  task automatic brd(bit a, output logic [7:0] v);
    @(negedge clk); rd = 1; addr = a;
    @(negedge clk); rd = 0;
    v = rdata;
  endtask

  task automatic rdx(string r, bit a, logic [7:0] exp);
    logic [7:0] v;
    brd(a, v);
    chk(r, v, exp);
  endtask

  task automatic key(logic [7:0] last);
    bwr(0, 8'h87); bwr(0, 8'h01); bwr(0, 8'h55); bwr(0, last);
  endtask

  task automatic setreg(logic [7:0] i, logic [7:0] d);
    bwr(0, i); bwr(1, d);
  endtask

  function automatic logic [7:0] pick();
    case ($urandom % 12)
      0: return 8'h87;  1: return 8'h01;  2: return 8'h55;  3: return 8'hAA;
      4: return 8'h02;  5: return 8'h07;  6: return 8'h20;  7: return 8'h21;
      8: return 8'h24;  9: return 8'h64;  10: return 8'h65;
      default: return 8'($urandom);
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    chk("R13 reset rdata", rdata, 8'hFF);
    chk("R1 reset locked", cfg_mode, 0);
    chk("R9 reset gctl", gctl, 8'h00);
    chk("R10 reset base", base, 16'h0820);
    // locked behaviour
    bwr(1, 8'h1F);
    chk("R4 locked write", gctl, 8'h00);
    rdx("R4 locked data read", 1, 8'hFF);
    rdx("R4 locked index read", 0, 8'hFF);
    // strap 0: wrong final byte, then right
    key(8'hAA);
    chk("R2 strap0 AA rejected", cfg_mode, 0);
    key(8'h55);
    chk("R1 unlock strap0", cfg_mode, 1);
    bwr(0, 8'h21);
    rdx("R5 index readback", 0, 8'h21);
    rdx("R7 id low", 1, 8'h16);
    setreg(8'h20, 8'h00);
    rdx("R7 id high after write", 1, 8'h87);
    setreg(8'h07, 8'h05);
    rdx("R8 ldn readback", 1, 8'h05);
    setreg(8'h64, 8'h03);
    rdx("R12 base hi gated", 1, 8'h00);
    chk("R12 base unchanged", base, 16'h0820);
    setreg(8'h33, 8'h5A);
    rdx("R12 unimplemented", 1, 8'h00);
    setreg(8'h07, 8'h07);
    setreg(8'h64, 8'hFF);
    rdx("R10 base hi", 1, 8'h0F);
    chk("R10 base out", base, 16'h0F20);
    setreg(8'h65, 8'hFF);
    rdx("R10 base lo", 1, 8'hF8);
    setreg(8'h64, 8'h00);
    chk("R10 base hi clear", base, 16'h00F8);
    setreg(8'h65, 8'h00);
    chk("R11 zero rejected", base, 16'h00F8);
    setreg(8'h65, 8'h0F);
    rdx("R10 lo alignment", 1, 8'h08);
    setreg(8'h24, 8'hFF);
    chk("R9 gctl out", gctl, 8'h1F);
    pin_sel = 1;
    rdx("R9 gctl read pin", 1, 8'h3F);
    repeat (3) @(negedge clk);
    chk("R13 rdata hold", rdata, 8'h3F);
    setreg(8'h02, 8'h01);
    chk("R6 non-exit value", cfg_mode, 1);
    bwr(1, 8'h02);
    chk("R6 exit", cfg_mode, 0);
    rdx("R4 relocked read", 1, 8'hFF);
    // strap 1, re-sync cases
    strap = 1;
    bwr(0, 8'h87); key(8'hAA);
    chk("R3 double first byte", cfg_mode, 1);
    setreg(8'h02, 8'h02);
    bwr(0, 8'h87); bwr(0, 8'h01); key(8'hAA);
    chk("R3 resync mid key", cfg_mode, 1);
    setreg(8'h02, 8'h02);
    key(8'h55);
    chk("R2 strap1 55 rejected", cfg_mode, 0);
    bwr(0, 8'h87); bwr(0, 8'h33); bwr(0, 8'h01); bwr(0, 8'h55); bwr(0, 8'hAA);
    chk("R3 restart after wrong", cfg_mode, 0);
    // random phase against the model
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = $urandom % 20;
      if (r == 0) begin
        strap = $urandom % 2; pin_sel = $urandom % 2;
      end else if (r < 3 && !m_unl) begin
        key(strap ? 8'hAA : 8'h55);
        chk("R1 random unlock", cfg_mode, m_unl);
      end else if (r < 12) begin
        bit a;
        a = $urandom % 2;
        bwr(a, pick());
        chk("R1 mode track", cfg_mode, m_unl);
        chk("R9 gctl track", gctl, {2'b00, pin_sel, m_gctl});
        chk("R10 base track", base, m_base);
      end else begin
        bit a;
        string rq;
        a = $urandom % 2;
        rq = req_of(a);
        brd(a, v);
        chk(rq, v, model_rd(a));
      end
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule